// File: doc/BRIEF.md
# Banked byte register file

This block is the host-side control register file of a network controller. It holds 32 byte-wide locations reached over a simple synchronous request bus. The byte address coming from the bus is first divided by a fixed stride (1, 2 or 4), so the same block can sit on an 8-, 16- or 32-bit host bus where each register takes up one lane.

The window of offsets 8 to 15 is shared by three banks. A two-bit selector in the configuration register (offset 7) chooses between the primary bank, which holds the six station-address bytes, an eight-byte multicast filter bank and an eight-byte buffer-port bank. Two status bytes collect transmit and receive events from the datapath. Software clears them by writing ones. Each status byte has an enable byte, and the block raises an interrupt while any enabled status bit is set. The configuration register carries a fixed identification field that software cannot change. The station address is loaded from a configuration input during reset.

Top module: `nic_reg_file`

## Requirements
- R1: The register offset is the bus byte address shifted right by log2(STRIDE). Address bits below the stride are ignored.
- R2: A read request (`req_i`=1, `we_i`=0) returns the addressed register on `rdata_o` one clock later, showing the value before any write in the same cycle. `rdata_o` holds its value when there is no read, and it is 0 after reset.
- R3: A write to offset 0 (transmit status) or offset 1 (receive status) clears exactly the bits that are 1 in the write data.
- R4: Bits [7:6] of offset 7 hold the identification code ID_CODE (default 2'b10) and never change. After reset, offset 7 reads {ID_CODE, 6'b0}. A write to offset 7 updates bits [5:0] only.
- R5: Bits [3:2] of offset 7 select the bank for offsets 8 to 15: 00 and 11 select the primary bank, 01 the multicast bank and 10 the buffer-port bank. Each bank keeps its contents while another bank is selected.
- R6: `tx_set_i` and `rx_set_i` OR their bits into status offsets 0 and 1 on every clock. A set bit wins over a clear of the same bit in the same cycle.
- R7: Offsets 2, 3 and 6, primary offsets 8 to 13, and all eight bytes of the multicast and buffer-port banks are plain read/write bytes. The two banks reset to 0.
- R8: `irq_o` is 1 exactly when (offset0 & offset2) | (offset1 & offset3) is non-zero in the current register contents.
- R9: During reset, primary offset 8+k (k = 0..5) is loaded from `mac_cfg_i[8k+7:8k]`. Offsets 0, 1, 2, 3 and 6 reset to 0.
- R10: Primary offsets 14 and 15, offsets 4, 5 and 16 to 31, and any offset of 32 or more after division read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_cfg_i | input | 48 | Station-address bytes loaded at reset, byte k at bits [8k+7:8k] |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, before stride division |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| tx_set_i | input | 8 | Transmit status bits to set |
| rx_set_i | input | 8 | Receive status bits to set |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the collision between a hardware set and a software clear on the same status bit in the same cycle. It needs a status pulse exactly aligned with a bus write to offset 0 or 1. The bench drives both from one task in the same cycle, then reads the byte back. The bank window is another hard case, because the same offset must show three different contents. The stimulus fills each bank with a distinct pattern, switches the selector back and forth (including the 11 alias), and confirms every bank kept its data. The bench runs with a stride of 2 and drives odd addresses, so the stride division is exercised on every access.

// File: rtl/nic_reg_pkg.sv
`timescale 1ns/1ps
package nic_reg_pkg;
  typedef enum logic [1:0] {
    BANK_PRI     = 2'b00,
    BANK_MCAST   = 2'b01,
    BANK_BUF     = 2'b10,
    BANK_PRI_ALT = 2'b11
  } bank_e;

  localparam int unsigned OFF_W      = 5;
  localparam int unsigned BANK_DEPTH = 8;
  localparam int unsigned MAC_BYTES  = 6;

  localparam logic [OFF_W-1:0] OFF_TX_EN = 5'd2;
  localparam logic [OFF_W-1:0] OFF_RX_EN = 5'd3;
  localparam logic [OFF_W-1:0] OFF_MODE  = 5'd6;
  localparam logic [OFF_W-1:0] OFF_CFG   = 5'd7;
endpackage

// File: rtl/nic_addr_div.sv
`timescale 1ns/1ps
module nic_addr_div #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STRIDE = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [4:0]        off_o,
  output logic              hit_o
);
  localparam int unsigned SHIFT = (STRIDE == 4) ? 2 : (STRIDE == 2) ? 1 : 0;

  logic [ADDR_W-1:0] idx;
  assign idx   = addr_i >> SHIFT;
  assign off_o = idx[4:0];

  if (ADDR_W > 5) begin : g_range
    assign hit_o = (idx[ADDR_W-1:5] == '0);
  end else begin : g_full
    assign hit_o = 1'b1;
  end
endmodule

// File: rtl/nic_byte_bank.sv
`timescale 1ns/1ps
module nic_byte_bank #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/nic_w1c_byte.sv
`timescale 1ns/1ps
module nic_w1c_byte (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [7:0] mask_i,
  input  logic [7:0] set_i,
  output logic [7:0] q_o
);
  // set is ORed after the clear so hardware events are never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~(clr_i ? mask_i : 8'h00)) | set_i;
  end
endmodule

// File: rtl/nic_reg_file.sv
`timescale 1ns/1ps
module nic_reg_file
  import nic_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STRIDE  = 1,
  parameter logic [1:0]  ID_CODE = 2'b10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [8*MAC_BYTES-1:0] mac_cfg_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [7:0]             tx_set_i,
  input  logic [7:0]             rx_set_i,
  output logic                   irq_o
);
  localparam int unsigned IDX_W = $clog2(BANK_DEPTH);

  logic [4:0]       off;
  logic             hit;
  logic             wr, rd, win, pri_win;
  logic [IDX_W-1:0] idx;
  bank_e            bank;
  logic [7:0]       en_q [2];
  logic [7:0]       mode_q, cfg_q;
  logic [7:0]       mac_q [MAC_BYTES];
  logic [7:0]       stat_q [2];
  logic [7:0]       set_vec [2];
  logic [7:0]       bank_rd [2];
  logic             bank_we [2];
  logic [7:0]       rd_val;

  nic_addr_div #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_div (
    .addr_i(addr_i), .off_o(off), .hit_o(hit)
  );

  assign wr      = req_i & we_i & hit;
  assign rd      = req_i & ~we_i;
  assign idx     = off[IDX_W-1:0];
  assign bank    = bank_e'(cfg_q[3:2]);
  assign win     = hit && (off[4:3] == 2'b01);
  assign pri_win = win && (bank == BANK_PRI || bank == BANK_PRI_ALT);

  assign bank_we[0] = wr && win && (bank == BANK_MCAST);
  assign bank_we[1] = wr && win && (bank == BANK_BUF);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    nic_byte_bank #(.DEPTH(BANK_DEPTH)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bank_we[b]), .idx_i(idx),
      .wdata_i(wdata_i), .rdata_o(bank_rd[b])
    );
  end

  assign set_vec[0] = tx_set_i;
  assign set_vec[1] = rx_set_i;

  for (genvar g = 0; g < 2; g++) begin : g_stat
    nic_w1c_byte u_stat (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .clr_i(wr && (off == 5'(g))), .mask_i(wdata_i),
      .set_i(set_vec[g]), .q_o(stat_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q[0] <= '0;
      en_q[1] <= '0;
      mode_q  <= '0;
      cfg_q   <= {ID_CODE, 6'b0};
      for (int k = 0; k < MAC_BYTES; k++) mac_q[k] <= mac_cfg_i[8*k +: 8];
    end else if (wr) begin
      case (off)
        OFF_TX_EN: en_q[0] <= wdata_i;
        OFF_RX_EN: en_q[1] <= wdata_i;
        OFF_MODE:  mode_q  <= wdata_i;
        OFF_CFG:   cfg_q   <= {cfg_q[7:6], wdata_i[5:0]};
        default: if (pri_win && idx < IDX_W'(MAC_BYTES)) mac_q[idx] <= wdata_i;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (off)
        5'd0:      rd_val = stat_q[0];
        5'd1:      rd_val = stat_q[1];
        OFF_TX_EN: rd_val = en_q[0];
        OFF_RX_EN: rd_val = en_q[1];
        OFF_MODE:  rd_val = mode_q;
        OFF_CFG:   rd_val = cfg_q;
        default: begin
          if (win) begin
            case (bank)
              BANK_MCAST: rd_val = bank_rd[0];
              BANK_BUF:   rd_val = bank_rd[1];
              default:    if (idx < IDX_W'(MAC_BYTES)) rd_val = mac_q[idx];
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end

  assign irq_o = |(stat_q[0] & en_q[0]) | |(stat_q[1] & en_q[1]);
endmodule

// File: rtl/nic_reg_file_chk.sv
`timescale 1ns/1ps
module nic_reg_file_chk #(
  parameter logic [1:0] ID_CODE = 2'b10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] tx_set_i,
  input logic [7:0] rx_set_i,
  input logic       hit_i,
  input logic [4:0] off_i,
  input logic [7:0] tx_stat_i,
  input logic [7:0] rx_stat_i,
  input logic [7:0] cfg_i,
  input logic [7:0] rdata_i,
  input logic       irq_i
);
  a_r4_id_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (cfg_i[7:6] == ID_CODE));

  a_r3_tx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit_i && off_i == 5'd0 && tx_set_i == 8'h00)
      |=> ((tx_stat_i & $past(wdata_i)) == 8'h00));

  a_r3_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit_i && off_i == 5'd1 && rx_set_i == 8'h00)
      |=> ((rx_stat_i & $past(wdata_i)) == 8'h00));

  a_r6_tx_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_set_i != 8'h00) |=> ((tx_stat_i & $past(tx_set_i)) == $past(tx_set_i)));

  a_r6_rx_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_set_i != 8'h00) |=> ((rx_stat_i & $past(rx_set_i)) == $past(rx_set_i)));

  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (tx_stat_i != 8'h00 || rx_stat_i != 8'h00));

  a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit_i) |=> (rdata_i == 8'h00));
endmodule

bind nic_reg_file nic_reg_file_chk #(.ID_CODE(ID_CODE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .wdata_i(wdata_i), .tx_set_i(tx_set_i), .rx_set_i(rx_set_i),
  .hit_i(hit), .off_i(off), .tx_stat_i(stat_q[0]), .rx_stat_i(stat_q[1]),
  .cfg_i(cfg_q), .rdata_i(rdata_o), .irq_i(irq_o)
);

// File: tb/tb_nic_reg_file.sv
`timescale 1ns/1ps
module tb_nic_reg_file;
  localparam int ADDR_W = 8;
  localparam int STRIDE = 2;
  localparam logic [47:0] MAC = 48'h665544332211;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, tx_set_i = '0, rx_set_i = '0;
  logic [7:0] rdata_o;
  logic irq_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R2";

  int m_pri [32];
  int m_mc [8];
  int m_bf [8];
  int m_rdata = 0;

  always #2.5 clk_i = ~clk_i;

  nic_reg_file #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .ID_CODE(2'b10)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mac_cfg_i(MAC), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .tx_set_i(tx_set_i), .rx_set_i(rx_set_i), .irq_o(irq_o)
  );

  function automatic int m_bank();
    return (m_pri[7] >> 2) & 3;
  endfunction

  function automatic int m_read(int off);
    if (off >= 32) return 0;
    if (off inside {0, 1, 2, 3, 6, 7}) return m_pri[off];
    if (off >= 8 && off <= 15) begin
      if (m_bank() == 1) return m_mc[off-8];
      if (m_bank() == 2) return m_bf[off-8];
      return (off <= 13) ? m_pri[off] : 0;
    end
    return 0;
  endfunction

  function automatic bit m_irq();
    return ((m_pri[0] & m_pri[2]) | (m_pri[1] & m_pri[3])) != 0;
  endfunction

  task automatic m_reset();
    foreach (m_pri[i]) m_pri[i] = 0;
    foreach (m_mc[i]) begin m_mc[i] = 0; m_bf[i] = 0; end
    m_pri[7] = 'h80;
    for (int k = 0; k < 6; k++) m_pri[8+k] = (MAC >> (8*k)) & 'hFF;
    m_rdata = 0;
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      int off, d;
      off = int'(addr_i) / STRIDE;
      d   = int'(wdata_i);
      if (req_i && !we_i) m_rdata = m_read(off);
      if (req_i && we_i && off < 32) begin
        case (off)
          0: m_pri[0] &= ~d & 'hFF;
          1: m_pri[1] &= ~d & 'hFF;
          2, 3, 6: m_pri[off] = d;
          7: m_pri[7] = (m_pri[7] & 'hC0) | (d & 'h3F);
          default:
            if (off >= 8 && off <= 15) begin
              if (m_bank() == 1)      m_mc[off-8] = d;
              else if (m_bank() == 2) m_bf[off-8] = d;
              else if (off <= 13)     m_pri[off] = d;
            end
        endcase
      end
      m_pri[0] |= int'(tx_set_i);
      m_pri[1] |= int'(rx_set_i);
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare to the model on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({cur_tag, " rdata"}, int'(rdata_o), m_rdata);
      chk("R8 irq", int'(irq_o), int'(m_irq()));
    end
  end

  task automatic bus(bit rq, bit w, int a, int d, int txs, int rxs);
    req_i = rq; we_i = w; addr_i = ADDR_W'(a); wdata_i = 8'(d);
    tx_set_i = 8'(txs); rx_set_i = 8'(rxs);
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0; tx_set_i = '0; rx_set_i = '0;
  endtask

  task automatic wr(int off, int d);
    bus(1, 1, off*STRIDE, d, 0, 0);
  endtask

  task automatic rd_chk(string tag, int off, int exp);
    bus(1, 0, off*STRIDE + 1, 0, 0, 0);
    chk(tag, int'(rdata_o), exp);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    chk("R2 reset rdata", int'(rdata_o), 0);
    chk("R8 reset irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur_tag = "R9";
    rd_chk("R4 id at reset", 7, 'h80);
    for (int k = 0; k < 6; k++) rd_chk("R9 mac preload", 8 + k, (MAC >> (8*k)) & 'hFF);
    rd_chk("R9 tx_en reset", 2, 0);
    cur_tag = "R10";
    rd_chk("R10 primary 14", 14, 0);
    rd_chk("R10 offset 4", 4, 0);
    wr(5, 'h77);
    rd_chk("R10 offset 5 write ignored", 5, 0);
    wr(20, 'h55);
    rd_chk("R10 offset 20 write ignored", 20, 0);

    cur_tag = "R4";
    wr(7, 'hFF);
    rd_chk("R4 id kept", 7, 'hBF);
    rd_chk("R5 select 11 is primary", 8, 'h11);

    cur_tag = "R5";
    wr(7, 'h04);
    for (int i = 0; i < 8; i++) wr(8 + i, 'hA0 + i);
    rd_chk("R5 mcast first", 8, 'hA0);
    rd_chk("R7 mcast last", 15, 'hA7);
    wr(7, 'h08);
    rd_chk("R7 buf reset zero", 8, 0);
    wr(15, 'hB5);
    rd_chk("R7 buf write", 15, 'hB5);
    wr(7, 'h00);
    rd_chk("R5 primary back", 8, 'h11);
    rd_chk("R10 primary 15", 15, 0);
    wr(9, 'h5A);
    rd_chk("R7 mac write", 9, 'h5A);
    wr(7, 'h04);
    rd_chk("R5 mcast retained", 9, 'hA1);
    wr(7, 'h08);
    rd_chk("R5 buf retained", 15, 'hB5);
    wr(7, 'h00);

    cur_tag = "R1";
    bus(1, 1, 6*STRIDE + 1, 'h3C, 0, 0);
    rd_chk("R1 odd address write", 6, 'h3C);
    bus(1, 1, 80, 'hFF, 0, 0);
    bus(1, 0, 81, 0, 0, 0);
    chk("R10 beyond 31 reads zero", int'(rdata_o), 0);
    rd_chk("R10 no alias at 40", 8, 'h11);

    cur_tag = "R6";
    bus(0, 0, 0, 0, 'h0F, 0);
    rd_chk("R6 tx set", 0, 'h0F);
    wr(0, 'h05);
    rd_chk("R3 tx w1c", 0, 'h0A);
    bus(1, 1, 0, 'h0A, 'h02, 0);
    rd_chk("R6 set beats clear", 0, 'h02);
    bus(0, 0, 0, 0, 0, 'hF0);
    wr(1, 'h30);
    rd_chk("R3 rx w1c", 1, 'hC0);
    bus(1, 0, 0, 0, 'h40, 0);
    chk("R2 read shows pre-set value", int'(rdata_o), 'h02);

    cur_tag = "R8";
    wr(2, 'h02);
    chk("R8 tx irq on", int'(irq_o), 1);
    wr(2, 'h01);
    chk("R8 tx masked", int'(irq_o), 0);
    wr(3, 'h80);
    chk("R8 rx irq on", int'(irq_o), 1);
    wr(1, 'hFF);
    chk("R8 rx cleared", int'(irq_o), 0);
    rd_chk("R3 rx all cleared", 1, 0);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule